// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Edge Interrupts

The block is a register-mapped bank of sixteen general-purpose pins on a simple 32-bit bus. The bus has an address, a write strobe, write data and combinational read data. Software chooses the direction of each pin and sets the value driven on pins used as outputs. It can read the pins after they have been synchronized to the block clock.

Each pin has a two-bit code that selects which edges it detects: rising, falling, both, or none. A detected edge sets a sticky status bit, and software clears that bit by writing a one to it. The block drives one combined interrupt line from the enabled status bits. It also drives a one-cycle wake request for each newly detected edge on a pin whose wake enable is set.

Output data, interrupt enable and wake enable can each be written in full, or changed bit by bit through write-only set and clear alias addresses. With the aliases, software can change one bit without a read-modify-write sequence.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, register 0x34 reads 0xFFFF (all pins are inputs) and `pin_oe_o` is 0. Registers 0x18, 0x1C, 0x28, 0x30, 0x38 and 0x3C read 0, and `irq_o` and `wake_o` are low.
- R2: Address 0x00 is read-only and returns the major version in bits 7:4 and the minor version in bits 3:0 (defaults 1 and 0, so it reads 0x10).
- R3: In register 0x34, a bit value of 1 makes that pin an input. `pin_oe_o` is the inverse of register 0x34. `pin_o` carries the output register 0x30 on output pins and 0 on input pins, starting from the cycle after the write.
- R4: A write to a set alias ORs the written mask into its target, and a write to a clear alias removes the masked bits. The set aliases are 0xF0 (output data), 0xDC (interrupt enable) and 0xE8 (wake enable). The clear aliases are 0xB0, 0x9C and 0xA8 for the same three registers. Zero bits in the mask leave the target unchanged, and every alias address reads 0.
- R5: Register 0x2C returns `pin_i` through a two-flop synchronizer. A pin change becomes visible in 0x2C after the second rising clock edge.
- R6: Each pin's edge code lies at bits 2*(pin mod 8)+1 : 2*(pin mod 8). Pins 0 to 7 use register 0x38 and pins 8 to 15 use register 0x3C. Code 00 disables detection, 01 detects rising edges, 10 detects falling edges and 11 detects both.
- R7: A selected edge sets its bit in the status register 0x18 after the third rising clock edge following the pin change, whether or not that pin's interrupt is enabled. The bit stays set until software clears it.
- R8: Writing 1 to a bit of 0x18 clears it, and writing 0 leaves it unchanged. If a clear and a new edge on the same pin land in the same cycle, the bit stays set.
- R9: `irq_o` is the OR of (status AND interrupt enable 0x1C). It follows an enable or status change in the same cycle that the register updates.
- R10: `wake_o` is high for exactly one cycle, in the same cycle the status bit sets, when a newly detected edge hits a pin whose wake-enable bit in 0x28 is 1. It stays low for edges on pins without wake enable.
- R11: Address 0x10 is a read/write configuration byte (bits 7:0, reset 0). Address 0x14 reads 1, meaning reset is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pin_i | input | 16 | Raw pin levels from the pads |
| pin_o | output | 16 | Output levels to the pads |
| pin_oe_o | output | 16 | Output enables, 1 = drive |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | One-cycle wake request |

## Verification
Register writes take effect at the rising edge that samples `we_i`. The bench checks read data, `pin_o` and `irq_o` one nanosecond after that edge, because all three follow the registers without extra delay.

A pin change needs two edges to appear in 0x2C, and three edges to set status and raise `wake_o`. The bench changes `pin_i` just after an edge and counts exactly two or three further edges before it samples. It then confirms that `wake_o` has fallen one edge later.

For the same-cycle clear-and-edge case, the bench times its status write so that the write lands on the third edge after the pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned PINS_PER_CTRL = 8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [7:0] OFS_REV      = 8'h00;
  localparam logic [7:0] OFS_CFG      = 8'h10;
  localparam logic [7:0] OFS_STS      = 8'h14;
  localparam logic [7:0] OFS_IRQSTAT  = 8'h18;
  localparam logic [7:0] OFS_IRQEN    = 8'h1C;
  localparam logic [7:0] OFS_WAKEEN   = 8'h28;
  localparam logic [7:0] OFS_DIN      = 8'h2C;
  localparam logic [7:0] OFS_DOUT     = 8'h30;
  localparam logic [7:0] OFS_DIR      = 8'h34;
  localparam logic [7:0] OFS_EDGE_LO  = 8'h38;
  localparam logic [7:0] OFS_EDGE_HI  = 8'h3C;
  localparam logic [7:0] OFS_CLR_IE   = 8'h9C;
  localparam logic [7:0] OFS_CLR_WAKE = 8'hA8;
  localparam logic [7:0] OFS_CLR_DOUT = 8'hB0;
  localparam logic [7:0] OFS_SET_IE   = 8'hDC;
  localparam logic [7:0] OFS_SET_WAKE = 8'hE8;
  localparam logic [7:0] OFS_SET_DOUT = 8'hF0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned CTRL_W = 2 * PINS_PER_CTRL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  sync_i,
  input  logic [CTRL_W-1:0] edge_lo_i,
  input  logic [CTRL_W-1:0] edge_hi_i,
  output logic [NPINS-1:0]  evt_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    edge_sel_e sel;
    logic      rise, fall;
    if (p < PINS_PER_CTRL) begin : g_lo
      assign sel = edge_sel_e'(edge_lo_i[2*p +: 2]);
    end else begin : g_hi
      assign sel = edge_sel_e'(edge_hi_i[2*(p-PINS_PER_CTRL) +: 2]);
    end
    assign rise = sync_i[p] & ~prev_q[p];
    assign fall = ~sync_i[p] & prev_q[p];
    always_comb begin
      unique case (sel)
        EDGE_RISE: evt_o[p] = rise;
        EDGE_FALL: evt_o[p] = fall;
        EDGE_BOTH: evt_o[p] = rise | fall;
        default:   evt_o[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] evt_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] ie_i,
  input  logic [NPINS-1:0] wake_en_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [NPINS-1:0] status_q;
  logic             wake_q;

  // new edges win over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      wake_q   <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | evt_i;
      wake_q   <= |(evt_i & wake_en_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ie_i);
  assign wake_o   = wake_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS     = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_W    = 2 * PINS_PER_CTRL,
  parameter logic [3:0]  REV_MAJOR = 4'd1,
  parameter logic [3:0]  REV_MINOR = 4'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  din_i,
  input  logic [NPINS-1:0]  status_i,
  output logic [NPINS-1:0]  dout_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  ie_o,
  output logic [NPINS-1:0]  wake_en_o,
  output logic [CTRL_W-1:0] edge_lo_o,
  output logic [CTRL_W-1:0] edge_hi_o,
  output logic [NPINS-1:0]  clr_o
);
  localparam int unsigned CFG_W = 8;

  logic [NPINS-1:0]  dout_q, dir_q, ie_q, wake_q;
  logic [NPINS-1:0]  dout_d, dir_d, ie_d, wake_d;
  logic [CTRL_W-1:0] elo_q, ehi_q, elo_d, ehi_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [NPINS-1:0]  mask;
  logic              wdata_unused;

  assign mask         = wdata_i[NPINS-1:0];
  assign wdata_unused = ^wdata_i[DATA_W-1:NPINS];

  always_comb begin
    dout_d = dout_q;
    dir_d  = dir_q;
    ie_d   = ie_q;
    wake_d = wake_q;
    elo_d  = elo_q;
    ehi_d  = ehi_q;
    cfg_d  = cfg_q;
    clr_o  = '0;
    if (we_i) begin
      unique case (addr_i)
        ADDR_W'(OFS_CFG):      cfg_d  = wdata_i[CFG_W-1:0];
        ADDR_W'(OFS_IRQSTAT):  clr_o  = mask;
        ADDR_W'(OFS_IRQEN):    ie_d   = mask;
        ADDR_W'(OFS_WAKEEN):   wake_d = mask;
        ADDR_W'(OFS_DOUT):     dout_d = mask;
        ADDR_W'(OFS_DIR):      dir_d  = mask;
        ADDR_W'(OFS_EDGE_LO):  elo_d  = wdata_i[CTRL_W-1:0];
        ADDR_W'(OFS_EDGE_HI):  ehi_d  = wdata_i[CTRL_W-1:0];
        ADDR_W'(OFS_SET_IE):   ie_d   = ie_q | mask;
        ADDR_W'(OFS_CLR_IE):   ie_d   = ie_q & ~mask;
        ADDR_W'(OFS_SET_WAKE): wake_d = wake_q | mask;
        ADDR_W'(OFS_CLR_WAKE): wake_d = wake_q & ~mask;
        ADDR_W'(OFS_SET_DOUT): dout_d = dout_q | mask;
        ADDR_W'(OFS_CLR_DOUT): dout_d = dout_q & ~mask;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '1;
      ie_q   <= '0;
      wake_q <= '0;
      elo_q  <= '0;
      ehi_q  <= '0;
      cfg_q  <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      ie_q   <= ie_d;
      wake_q <= wake_d;
      elo_q  <= elo_d;
      ehi_q  <= ehi_d;
      cfg_q  <= cfg_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_REV):     rdata_o = DATA_W'({REV_MAJOR, REV_MINOR});
      ADDR_W'(OFS_CFG):     rdata_o = DATA_W'(cfg_q);
      ADDR_W'(OFS_STS):     rdata_o = DATA_W'(1);
      ADDR_W'(OFS_IRQSTAT): rdata_o = DATA_W'(status_i);
      ADDR_W'(OFS_IRQEN):   rdata_o = DATA_W'(ie_q);
      ADDR_W'(OFS_WAKEEN):  rdata_o = DATA_W'(wake_q);
      ADDR_W'(OFS_DIN):     rdata_o = DATA_W'(din_i);
      ADDR_W'(OFS_DOUT):    rdata_o = DATA_W'(dout_q);
      ADDR_W'(OFS_DIR):     rdata_o = DATA_W'(dir_q);
      ADDR_W'(OFS_EDGE_LO): rdata_o = DATA_W'(elo_q);
      ADDR_W'(OFS_EDGE_HI): rdata_o = DATA_W'(ehi_q);
      default:              rdata_o = '0;
    endcase
  end

  assign dout_o    = dout_q;
  assign dir_o     = dir_q;
  assign ie_o      = ie_q;
  assign wake_en_o = wake_q;
  assign edge_lo_o = elo_q;
  assign edge_hi_o = ehi_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  REV_MAJOR   = 4'd1,
  parameter logic [3:0]  REV_MINOR   = 4'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned CTRL_W = 2 * PINS_PER_CTRL;

  logic [NPINS-1:0]  din, dout, dir, ie, wake_en, status, evt, clr;
  logic [CTRL_W-1:0] edge_lo, edge_hi;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (din)
  );

  gpio_edge_det #(.NPINS(NPINS), .CTRL_W(CTRL_W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (din),
    .edge_lo_i(edge_lo),
    .edge_hi_i(edge_hi),
    .evt_o    (evt)
  );

  gpio_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
    .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .din_i    (din),
    .status_i (status),
    .dout_o   (dout),
    .dir_o    (dir),
    .ie_o     (ie),
    .wake_en_o(wake_en),
    .edge_lo_o(edge_lo),
    .edge_hi_o(edge_hi),
    .clr_o    (clr)
  );

  gpio_irq_ctrl #(.NPINS(NPINS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .clr_i    (clr),
    .ie_i     (ie),
    .wake_en_i(wake_en),
    .status_o (status),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
  );

  assign pin_oe_o = ~dir;
  assign pin_o    = dout & ~dir;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTRL_W = 2 * PINS_PER_CTRL
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NPINS-1:0]  pin_o,
  input logic [NPINS-1:0]  pin_oe_o,
  input logic              wake_o,
  input logic [NPINS-1:0]  status_i,
  input logic [NPINS-1:0]  ie_i,
  input logic [NPINS-1:0]  wake_en_i,
  input logic [NPINS-1:0]  dout_i,
  input logic [NPINS-1:0]  evt_i,
  input logic [CTRL_W-1:0] edge_lo_i,
  input logic [CTRL_W-1:0] edge_hi_i
);
  logic [NPINS-1:0] off_mask;

  for (genvar p = 0; p < NPINS; p++) begin : g_off
    if (p < PINS_PER_CTRL) begin : g_lo
      assign off_mask[p] = (edge_lo_i[2*p +: 2] == 2'b00);
    end else begin : g_hi
      assign off_mask[p] = (edge_hi_i[2*(p-PINS_PER_CTRL) +: 2] == 2'b00);
    end
  end

  AST_OUT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0); // R3

  AST_SET_DOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_SET_DOUT)) |=>
    ((dout_i & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0]))); // R4

  AST_CLR_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_CLR_IE)) |=>
    ((ie_i & $past(wdata_i[NPINS-1:0])) == '0)); // R4

  AST_NO_EVT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & off_mask) == '0); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(OFS_IRQSTAT)) |=>
    ((status_i & $past(status_i)) == $past(status_i))); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_IRQSTAT)) |=>
    ((status_i & $past(wdata_i[NPINS-1:0]) & ~$past(evt_i)) == '0)); // R8

  AST_WAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ((status_i & $past(wake_en_i)) != '0)); // R10
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .wake_o   (wake_o),
  .status_i (status),
  .ie_i     (ie),
  .wake_en_i(wake_en),
  .dout_i   (dout),
  .evt_i    (evt),
  .edge_lo_i(edge_lo),
  .edge_hi_i(edge_hi)
);

// File: tb/gpio_edge_bank_tb.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pins = '0;
  logic [15:0] pout, poe;
  logic        irq, wake;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pout), .pin_oe_o(poe),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // change pins just after an edge, wait three edges: status/wake due
  task automatic drive_pins(input logic [15:0] v);
    pins = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk_reg("R1 dir", 8'h34, 32'h0000_FFFF);
    chk("R1 oe", {16'h0, poe}, 32'h0);
    chk_reg("R1 status", 8'h18, 32'h0);
    chk_reg("R1 ie", 8'h1C, 32'h0);
    chk_reg("R1 wake_en", 8'h28, 32'h0);
    chk_reg("R1 dout", 8'h30, 32'h0);
    chk_reg("R1 edge_lo", 8'h38, 32'h0);
    chk_reg("R1 edge_hi", 8'h3C, 32'h0);
    chk("R1 irq/wake", {30'h0, irq, wake}, 32'h0);
  endtask

  task automatic t_ident;
    chk_reg("R2 revision", 8'h00, 32'h0000_0010);
    wr(8'h00, 32'hFF);
    chk_reg("R2 revision read-only", 8'h00, 32'h0000_0010);
    chk_reg("R11 sysstatus", 8'h14, 32'h1);
    wr(8'h10, 32'h1234_56A5);
    chk_reg("R11 sysconfig", 8'h10, 32'h0000_00A5);
  endtask

  task automatic t_direction;
    wr(8'h34, 32'hFF00);
    wr(8'h30, 32'h5AA5);
    chk("R3 oe", {16'h0, poe}, 32'h0000_00FF);
    chk("R3 pin_o", {16'h0, pout}, 32'h0000_00A5);
  endtask

  task automatic t_alias;
    wr(8'h30, 32'h0F0F);
    wr(8'hF0, 32'h00F0);
    chk_reg("R4 set dout", 8'h30, 32'h0FFF);
    wr(8'hB0, 32'h0F00);
    chk_reg("R4 clr dout", 8'h30, 32'h00FF);
    chk("R4 pin_o after alias", {16'h0, pout}, 32'h00FF);
    wr(8'hDC, 32'h0300);
    chk_reg("R4 set ie", 8'h1C, 32'h0300);
    wr(8'h9C, 32'h0100);
    chk_reg("R4 clr ie", 8'h1C, 32'h0200);
    wr(8'hE8, 32'h0011);
    chk_reg("R4 set wake", 8'h28, 32'h0011);
    wr(8'hA8, 32'h0010);
    chk_reg("R4 clr wake", 8'h28, 32'h0001);
    chk_reg("R4 alias reads 0", 8'hF0, 32'h0);
    wr(8'h9C, 32'hFFFF);
    wr(8'hA8, 32'hFFFF);
    chk_reg("R4 ie cleared", 8'h1C, 32'h0);
  endtask

  task automatic t_sync;
    pins = 16'h1234;
    @(posedge clk); #1;
    chk_reg("R5 din after 1 edge", 8'h2C, 32'h0);
    @(posedge clk); #1;
    chk_reg("R5 din after 2 edges", 8'h2C, 32'h1234);
    drive_pins(16'h0000);
    chk_reg("R6 codes 00 no status", 8'h18, 32'h0);
  endtask

  task automatic t_edges;
    // pin0 rise, pin1 fall, pin2 both, pin3 off; pin9 rise in high reg
    wr(8'h38, 32'h0000_0039);
    wr(8'h3C, 32'h0000_0004);
    drive_pins(16'h020F);
    chk_reg("R6 rising set", 8'h18, 32'h0205);
    chk("R7 status without irq enable, irq low", {31'h0, irq}, 32'h0);
    wr(8'h18, 32'hFFFF);
    chk_reg("R8 clear all", 8'h18, 32'h0);
    drive_pins(16'h0000);
    chk_reg("R6 falling set", 8'h18, 32'h0006);
    repeat (4) @(posedge clk);
    #1 chk_reg("R7 sticky", 8'h18, 32'h0006);
  endtask

  task automatic t_w1c;
    wr(8'h18, 32'h0002);
    chk_reg("R8 W1C one bit", 8'h18, 32'h0004);
    wr(8'h18, 32'h0000);
    chk_reg("R8 write 0 no change", 8'h18, 32'h0004);
  endtask

  task automatic t_irq;
    wr(8'hDC, 32'h0020);
    chk("R9 irq off for idle pin", {31'h0, irq}, 32'h0);
    wr(8'hDC, 32'h0004);
    chk("R9 irq on", {31'h0, irq}, 32'h1);
    wr(8'h18, 32'h0004);
    chk("R9 irq drops with status", {31'h0, irq}, 32'h0);
    wr(8'h9C, 32'hFFFF);
  endtask

  task automatic t_collision;
    pins = 16'h0004;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    addr = 8'h18; wdata = 32'h0004; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
    chk_reg("R8 edge wins over clear", 8'h18, 32'h0004);
    drive_pins(16'h0000);
    wr(8'h18, 32'hFFFF);
    chk_reg("R8 cleared after collision", 8'h18, 32'h0);
  endtask

  task automatic t_wake;
    wr(8'hE8, 32'h0001);
    drive_pins(16'h0001);
    chk("R10 wake pulse", {31'h0, wake}, 32'h1);
    chk_reg("R10 status with wake", 8'h18, 32'h0001);
    @(posedge clk); #1;
    chk("R10 wake one cycle", {31'h0, wake}, 32'h0);
    drive_pins(16'h0003);
    drive_pins(16'h0001);
    chk("R10 no wake without enable", {31'h0, wake}, 32'h0);
    chk_reg("R10 status on pin1", 8'h18, 32'h0003);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_ident();
    t_direction();
    t_alias();
    t_sync();
    t_edges();
    t_w1c();
    t_irq();
    t_collision();
    t_wake();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule